// File: doc/BRIEF.md
# Three-Bank Phase-Aligned Clock Divider

This block takes a core clock that runs at twice a reference rate and produces three banks of registered clock levels. Bank A runs at the reference rate or at half of it. Banks B and C run at half or at a quarter of the reference rate. Each bank is a group of replicated flops, so that every fanout load has its own driver. A shared 3-bit phase counter cycles once every four reference periods. Every start, every stop and every change of ratio is tied to a fixed point of that counter, so the banks stay in phase with each other and never emit a shortened pulse.

An active-low reset clears every output at once, without waiting for a clock edge. The output enable passes through a synchronizer. Outputs start only when the phase counter wraps. On disable, each ratio class stops at the end of its own high phase, in a fixed order: the slowest first, then the middle one, then the fastest. A running flag per bank shows whether the ratio that bank currently uses is active. Any control pin can be declared absent by a parameter. An absent pin reads as logic 1.

Top module: `clk_bank_divider`

## Requirements
- R1: Bank A with its select at 0 gives high and low phases of 1 core cycle each (reference rate). With its select at 1 it gives phases of 2 core cycles each.
- R2: Banks B and C with their select at 0 give high and low phases of 2 core cycles each. With their select at 1 they give phases of 4 core cycles each.
- R3: While the reset is low, every bank output and every running flag is 0. This takes effect at once, without waiting for a clock edge, and regardless of the enable and the selects.
- R4: When the reset rises with the enable held at 1, all bank outputs rise together on the 8th core rising edge after the release (4 reference periods).
- R5: When the enable rises, all bank outputs and running flags rise on one common core edge. That edge is a phase-counter wrap (a multiple of 8 edges after reset release) and falls 4 to 11 core edges after the enable change.
- R6: When the enable falls, the quarter-rate class stops first, then the half-rate class, then the reference-rate class. The last output is low within 14 core edges of the enable change, and no output stops earlier than 4 edges after it.
- R7: While the enable stays low after the stop sequence, every output and running flag stays 0, whatever the selects do.
- R8: Every high pulse on any output lasts the full length of its ratio (1 or 2 cycles in bank A, 2 or 4 cycles in banks B and C). It starts on a core edge whose phase is a multiple of twice that length. This holds even when a select changes at an arbitrary cycle, because a new select takes effect only at a phase-counter wrap.
- R9: The running flag of a bank is 1 while the ratio class that bank currently uses is active. It falls on the same edge as that bank's final falling output edge.
- R10: A control pin whose bit in the pin-presence mask (bit 0 enable, bits 1 to 3 the selects of A, B and C, bit 4 reset) is 0 is ignored and reads as logic 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, twice the reference rate |
| rstN | input | 1 | Active-low asynchronous master reset |
| enIn | input | 1 | Output enable, asynchronous to the core clock |
| selA | input | 1 | Bank A ratio select (0 gives ÷1, 1 gives ÷2) |
| selB | input | 1 | Bank B ratio select (0 gives ÷2, 1 gives ÷4) |
| selC | input | 1 | Bank C ratio select (0 gives ÷2, 1 gives ÷4) |
| bankA | output | A_OUTS | Bank A clock levels |
| bankB | output | B_OUTS | Bank B clock levels |
| bankC | output | C_OUTS | Bank C clock levels |
| runA | output | 1 | Bank A running flag |
| runB | output | 1 | Bank B running flag |
| runC | output | 1 | Bank C running flag |

## Verification
The assertions assume the selects are synchronous to the core clock, since they are sampled directly at each phase wrap without a synchronizer. They also assume the reset is released away from a core edge. The enable alone may change at any time. The stimulus changes every control input half a cycle away from the active edge. Select values come both from directed sweeps and from random changes at random cycle counts while the banks run. Enable and disable requests are placed at random offsets from the phase wrap, so that the whole 4-to-11-edge latency window is covered.

// File: rtl/clk_bank_pkg.sv
package clk_bank_pkg;

  localparam int PH_W = 3;

  // index of the ratio class: also the phase bit that gives its level
  typedef enum logic [1:0] {
    RATIO_1 = 2'd0,
    RATIO_2 = 2'd1,
    RATIO_4 = 2'd2
  } ratio_e;

  // control -> datapath strobes
  typedef struct packed {
    logic [PH_W-1:0] ph;       // current phase
    logic [PH_W-1:0] phNext;   // phase after this edge
    logic [2:0]      runNext;  // active flag per ratio class, next value
    logic [2:0]      selNext;  // {C,B,A} selects in force after this edge
  } strobe_t;

  function automatic ratio_e ratioOfA(input logic sel);
    return sel ? RATIO_2 : RATIO_1;
  endfunction

  function automatic ratio_e ratioOfBC(input logic sel);
    return sel ? RATIO_4 : RATIO_2;
  endfunction

  function automatic logic levelFor(input ratio_e r, input logic [PH_W-1:0] ph,
                                    input logic [2:0] run);
    return run[int'(r)] & ~ph[int'(r)];
  endfunction

endpackage

// File: rtl/clk_bank_ctrl.sv
module clk_bank_ctrl
  import clk_bank_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       enRaw,
  input  logic [2:0] selRaw,
  output strobe_t    strobe
);

  localparam logic [PH_W-1:0] WRAP_PH  = '1;
  localparam logic [PH_W-1:0] STOP4_PH = PH_W'(3);
  localparam logic [PH_W-1:0] STOP2_PH = PH_W'(5);
  localparam logic [PH_W-1:0] STOP1_PH = PH_W'(6);

  logic [SYNC_STAGES:0] enChain;
  logic                 armed;
  logic [PH_W-1:0]      ph;
  logic [PH_W-1:0]      phNext;
  logic [2:0]           run;
  logic [2:0]           runNext;
  logic [2:0]           selQ;
  logic [2:0]           selNext;
  logic                 atWrap;

  assign enChain[0] = enRaw;

  for (genvar s = 1; s <= SYNC_STAGES; s++) begin : g_sync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) enChain[s] <= 1'b0;
      else       enChain[s] <= enChain[s-1];
    end
  end

  assign atWrap = (ph == WRAP_PH);
  assign phNext = ph + PH_W'(1);

  always_comb begin
    runNext = run;
    if (armed && atWrap) begin
      runNext = 3'b111;
    end else if (!armed) begin
      if (run[2] && ph == STOP4_PH)            runNext[2] = 1'b0;
      if (run[1] && !run[2] && ph == STOP2_PH) runNext[1] = 1'b0;
      if (run[0] && !run[1] && ph == STOP1_PH) runNext[0] = 1'b0;
    end
  end

  assign selNext = atWrap ? selRaw : selQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armed <= 1'b0;
      ph    <= '0;
      run   <= '0;
      selQ  <= '0;
    end else begin
      armed <= enChain[SYNC_STAGES];
      ph    <= phNext;
      run   <= runNext;
      selQ  <= selNext;
    end
  end

  assign strobe = '{ph: ph, phNext: phNext, runNext: runNext, selNext: selNext};

  // R6
  stop_order_2_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(run[1]) |-> !run[2]);

  // R6
  stop_order_1_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(run[0]) |-> !run[1]);

  // R5
  start_together_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(run[0]) |-> (run[2:1] == 2'b11));

endmodule

// File: rtl/clk_bank_dpath.sv
module clk_bank_dpath
  import clk_bank_pkg::*;
#(
  parameter int A_OUTS = 4,
  parameter int B_OUTS = 3,
  parameter int C_OUTS = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  output logic [A_OUTS-1:0] bankA,
  output logic [B_OUTS-1:0] bankB,
  output logic [C_OUTS-1:0] bankC,
  output logic              runA,
  output logic              runB,
  output logic              runC
);

  ratio_e ratA, ratB, ratC;
  logic   lvlA, lvlB, lvlC;

  assign ratA = ratioOfA(strobe.selNext[0]);
  assign ratB = ratioOfBC(strobe.selNext[1]);
  assign ratC = ratioOfBC(strobe.selNext[2]);

  assign lvlA = levelFor(ratA, strobe.phNext, strobe.runNext);
  assign lvlB = levelFor(ratB, strobe.phNext, strobe.runNext);
  assign lvlC = levelFor(ratC, strobe.phNext, strobe.runNext);

  // one flop per load keeps every output on its own driver
  for (genvar i = 0; i < A_OUTS; i++) begin : g_bankA
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) bankA[i] <= 1'b0;
      else       bankA[i] <= lvlA;
    end
  end

  for (genvar i = 0; i < B_OUTS; i++) begin : g_bankB
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) bankB[i] <= 1'b0;
      else       bankB[i] <= lvlB;
    end
  end

  for (genvar i = 0; i < C_OUTS; i++) begin : g_bankC
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) bankC[i] <= 1'b0;
      else       bankC[i] <= lvlC;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runA <= 1'b0;
      runB <= 1'b0;
      runC <= 1'b0;
    end else begin
      runA <= strobe.runNext[int'(ratA)];
      runB <= strobe.runNext[int'(ratB)];
      runC <= strobe.runNext[int'(ratC)];
    end
  end

  // R5
  start_on_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(runA) |-> (strobe.ph == '0) && bankA[0]);

  // R8
  no_runt_b_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(bankB[0]) |-> $past(bankB[0], 2));

endmodule

// File: rtl/clk_bank_divider.sv
module clk_bank_divider
  import clk_bank_pkg::*;
#(
  parameter int         A_OUTS      = 4,
  parameter int         B_OUTS      = 3,
  parameter int         C_OUTS      = 1,
  parameter int         SYNC_STAGES = 2,
  parameter logic [4:0] PIN_USED    = 5'b11111  // {rst, selC, selB, selA, en}
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enIn,
  input  logic              selA,
  input  logic              selB,
  input  logic              selC,
  output logic [A_OUTS-1:0] bankA,
  output logic [B_OUTS-1:0] bankB,
  output logic [C_OUTS-1:0] bankC,
  output logic              runA,
  output logic              runB,
  output logic              runC
);

  localparam int PIN_COUNT = 5;

  logic [PIN_COUNT-1:0] pinRaw;
  logic [PIN_COUNT-1:0] pinEff;
  strobe_t              strobe;

  assign pinRaw = {rstN, selC, selB, selA, enIn};

  // an absent pin reads as logic 1
  for (genvar p = 0; p < PIN_COUNT; p++) begin : g_tie
    if (PIN_USED[p]) begin : g_live
      assign pinEff[p] = pinRaw[p];
    end else begin : g_tied
      assign pinEff[p] = 1'b1;
    end
  end

  clk_bank_ctrl #(
    .SYNC_STAGES(SYNC_STAGES)
  ) ctrl_i (
    .clk   (clk),
    .rstN  (pinEff[4]),
    .enRaw (pinEff[0]),
    .selRaw(pinEff[3:1]),
    .strobe(strobe)
  );

  clk_bank_dpath #(
    .A_OUTS(A_OUTS),
    .B_OUTS(B_OUTS),
    .C_OUTS(C_OUTS)
  ) dpath_i (
    .clk   (clk),
    .rstN  (pinEff[4]),
    .strobe(strobe),
    .bankA (bankA),
    .bankB (bankB),
    .bankC (bankC),
    .runA  (runA),
    .runB  (runB),
    .runC  (runC)
  );

endmodule

// File: tb/clk_bank_divider_tb_top.sv
`timescale 1ns/1ps
module clk_bank_divider_tb_top;

  localparam int A_N = 4;
  localparam int B_N = 3;
  localparam int C_N = 1;

  logic clk = 1'b0;
  logic rstN, enIn, selA, selB, selC;
  logic [A_N-1:0] bankA;
  logic [B_N-1:0] bankB;
  logic [C_N-1:0] bankC;
  logic runA, runB, runC;
  logic [A_N-1:0] tieA;
  logic [B_N-1:0] tieB;
  logic [C_N-1:0] tieC;
  logic tieRunA, tieRunB, tieRunC;

  int vectors = 0;
  int miscompares = 0;
  int t;

  always #2.5 clk = ~clk;

  clk_bank_divider dut_i (
    .clk(clk), .rstN(rstN), .enIn(enIn), .selA(selA), .selB(selB), .selC(selC),
    .bankA(bankA), .bankB(bankB), .bankC(bankC), .runA(runA), .runB(runB), .runC(runC)
  );

  // selects absent: they must read as 1 (R10)
  clk_bank_divider #(.PIN_USED(5'b10001)) dut_tie_i (
    .clk(clk), .rstN(rstN), .enIn(enIn), .selA(selA), .selB(selB), .selC(selC),
    .bankA(tieA), .bankB(tieB), .bankC(tieC), .runA(tieRunA), .runB(tieRunB), .runC(tieRunC)
  );

  always @(posedge clk or negedge rstN) begin
    if (!rstN) t <= 0;
    else       t <= t + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d at t=%0d", req, act, exp, t);
    end
  endtask

  task automatic finishRun();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  function automatic bit lenOk(input int idx, input int len);
    if (idx == 0) return (len == 1) || (len == 2);
    if (idx == 3) return (len == 2);
    return (len == 2) || (len == 4);
  endfunction

  function automatic int expA(input logic s);
    return s ? 2 : 1;
  endfunction

  function automatic int expBC(input logic s);
    return s ? 4 : 2;
  endfunction

  // pulse monitor: every high pulse has a full length and an aligned start (R8)
  logic [3:0] monV;
  assign monV = {tieA[0], bankC[0], bankB[0], bankA[0]};
  int   startT [4];
  int   lastLen[4];
  logic prevV  [4];

  always @(negedge clk) begin
    for (int i = 0; i < 4; i++) begin
      if (!rstN) begin
        prevV[i] = 1'b0;
      end else begin
        if (monV[i] && !prevV[i]) startT[i] = t;
        if (!monV[i] && prevV[i]) begin
          int len;
          len = t - startT[i];
          lastLen[i] = len;
          chk(lenOk(i, len) && (startT[i] % (2 * len) == 0), "R8 pulse length/alignment", len, startT[i]);
        end
        prevV[i] = monV[i];
      end
    end
  end

  task automatic releaseAndCheck();
    int riseT;
    @(negedge clk);
    rstN = 1'b1;
    riseT = -1;
    for (int k = 0; k < 20 && riseT < 0; k++) begin
      @(negedge clk);
      if (bankA[0]) begin
        riseT = t;
        chk(bankB[0] && bankC[0] && tieA[0], "R4 banks rise together",
            {29'd0, bankA[0], bankB[0], bankC[0]}, 7);
      end
    end
    chk(riseT == 8, "R4 release latency", riseT, 8);
  endtask

  task automatic waitCycles(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  initial begin : watchdog
    #(5.0 * 150000);
    miscompares++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", t, 0);
    finishRun();
  end

  initial begin : stim
    int fA, fB, fC, rfA, rfB, rfC, t0, lat, riseT;
    logic pA, pB, pC, qA, qB, qC;
    void'($urandom(32'h5eed));
    rstN = 1'b0; enIn = 1'b1; selA = 1'b0; selB = 1'b0; selC = 1'b0;
    waitCycles(3);
    // R3 reset state
    chk(bankA == '0 && bankB == '0 && bankC == '0, "R3 outputs in reset", {bankA, bankB, bankC}, 0);
    chk({runA, runB, runC} == 3'b000, "R3 flags in reset", {runA, runB, runC}, 0);

    releaseAndCheck();

    // R1 R2 R9 R10: directed sweep then random selects
    for (int n = 0; n < 14; n++) begin
      logic [2:0] s;
      s = (n < 8) ? 3'(n) : 3'($urandom % 8);
      @(negedge clk);
      {selC, selB, selA} = s;
      waitCycles(24);
      chk(lastLen[0] == expA(selA), "R1 bank A phase length", lastLen[0], expA(selA));
      chk(lastLen[1] == expBC(selB), "R2 bank B phase length", lastLen[1], expBC(selB));
      chk(lastLen[2] == expBC(selC), "R2 bank C phase length", lastLen[2], expBC(selC));
      chk({runA, runB, runC} == 3'b111, "R9 flags while running", {runA, runB, runC}, 7);
      chk(lastLen[3] == 2, "R10 absent select reads 1", lastLen[3], 2);
    end

    // R3 asynchronous reset in mid cycle
    @(negedge clk);
    #1.2 rstN = 1'b0;
    #0.3;
    chk(bankA == '0 && bankB == '0 && bankC == '0, "R3 async clear", {bankA, bankB, bankC}, 0);
    chk({runA, runB, runC} == 3'b000, "R3 async flag clear", {runA, runB, runC}, 0);
    waitCycles(2);
    releaseAndCheck();

    // R6 R7 R9 disable ordering: A ratio 1, B ratio 2, C ratio 4
    @(negedge clk);
    selA = 1'b0; selB = 1'b0; selC = 1'b1;
    waitCycles(24);
    for (int rep = 0; rep < 4; rep++) begin
      waitCycles($urandom % 8);
      @(negedge clk);
      enIn = 1'b0; t0 = t;
      pA = bankA[0]; pB = bankB[0]; pC = bankC[0];
      qA = runA; qB = runB; qC = runC;
      fA = -1; fB = -1; fC = -1; rfA = -1; rfB = -1; rfC = -1;
      for (int k = 0; k < 24; k++) begin
        @(negedge clk);
        if (pA && !bankA[0]) fA = t;
        if (pB && !bankB[0]) fB = t;
        if (pC && !bankC[0]) fC = t;
        if (qA && !runA) rfA = t;
        if (qB && !runB) rfB = t;
        if (qC && !runC) rfC = t;
        pA = bankA[0]; pB = bankB[0]; pC = bankC[0];
        qA = runA; qB = runB; qC = runC;
      end
      chk(fC < fB && fB < fA, "R6 stop order", fC * 10000 + fB * 100 + fA, 0);
      chk(fA - t0 <= 14, "R6 last stop bound", fA - t0, 14);
      chk(fC - t0 >= 4, "R6 first stop bound", fC - t0, 4);
      chk(rfA == fA && rfB == fB && rfC == fC, "R9 flag falls with output", rfA, fA);
      // R7 held low while selects wander
      for (int k = 0; k < 10; k++) begin
        @(negedge clk);
        {selC, selB, selA} = 3'($urandom % 8);
      end
      waitCycles(10);
      chk(bankA == '0 && bankB == '0 && bankC == '0, "R7 outputs held low", {bankA, bankB, bankC}, 0);
      chk({runA, runB, runC} == 3'b000, "R7 flags held low", {runA, runB, runC}, 0);

      // R5 enable latency from a random offset
      waitCycles($urandom % 16);
      @(negedge clk);
      enIn = 1'b1; t0 = t; riseT = -1;
      for (int k = 0; k < 20 && riseT < 0; k++) begin
        @(negedge clk);
        if (bankA[0] || bankB[0] || bankC[0]) begin
          riseT = t;
          chk(bankA[0] && bankB[0] && bankC[0] && runA && runB && runC,
              "R5 common rising edge", {26'd0, bankA[0], bankB[0], bankC[0], runA, runB, runC}, 63);
        end
      end
      lat = riseT - t0;
      chk(lat >= 4 && lat <= 11, "R5 enable latency", lat, 4);
      chk(riseT % 8 == 0, "R5 rise on wrap", riseT % 8, 0);
      @(negedge clk);
      selA = 1'b0; selB = 1'b0; selC = 1'b1;
      waitCycles(24);
    end

    // R8 random select changes while running
    for (int n = 0; n < 60; n++) begin
      waitCycles(1 + ($urandom % 7));
      {selC, selB, selA} = 3'($urandom % 8);
    end
    waitCycles(24);
    chk({runA, runB, runC} == 3'b111, "R9 flags after random selects", {runA, runB, runC}, 7);

    finishRun();
  end

endmodule